// File: doc/BRIEF.md
# Stacked-Carrier Thirteen-Level Modulator

This block produces the eighteen switch commands for a thirteen-level, transformer-cascaded inverter. A phase accumulator drives a quarter-wave sine table. The sine value is scaled by a modulation index and then compared with twelve triangular carriers. The twelve carriers come from a single up/down counter, each one displaced by a whole band height. The comparison gives a signed level code from -6 to +6. A fixed switching table turns the level into a gate pattern. The level code and the gate pattern are registered together, and they change only on a carrier sample.

The phase increment sets the fundamental frequency: one sine cycle takes 2^PHASE_W / phase_inc clocks. With the default 32-bit accumulator and a 50 MHz clock, an increment of 4295 gives a 50 Hz output. While the block is disabled, the accumulator, the carrier and the output registers stay cleared, and the zero-level gate pattern is driven.

Top module: `lspwm_modulator`

## Requirements
- R1: During reset and in the cycle after any clock edge with enable low, level_o is 0 and gate_o is the zero-level pattern 18'h24924. Gate bit i is switch i+1, so the zero-level pattern has switches 3, 6, 9, 12, 15 and 18 on.
- R2: level_o is a 4-bit two's complement code, and its value always lies in -6..+6.
- R3: The level is the number of positive carriers strictly below the reference minus the number of negative carriers strictly above it. Positive carrier k (k = 1..6) is (k-1)*B + c and negative carrier k is -((k-1)*B + c), where B = 2^BAND_W and c is a triangle that counts 0..B-1..0, one step per sample. At full modulation, every level from -6 to +6 occurs within one sine cycle.
- R4: The reference peak is 6*B*min(mod_index, 2^(MI_W-1)) / 2^(MI_W-1), the same in both half cycles. Index 0 keeps the level at 0. Half scale gives extreme levels of exactly +3 and -3. Any index at or above full scale behaves as full scale.
- R5: The phase restarts at 0 when enable rises. The level is never negative during the first half of a sine cycle and never positive during the second half, apart from a few clocks of pipeline lag at each crossing.
- R6: level_o changes only on sample strobes. A strobe occurs every PRESCALE clocks, counted from the rise of enable.
- R7: Gate patterns for the non-negative levels, as the switches that are on: +6 -> 1,4,7,10,13,16; +5 -> 1,4,7,10,13,18; +4 -> 1,4,7,10,15,18; +3 -> 1,4,7,12,15,18; +2 -> 1,4,6,9,12,15,18; +1 -> 1,6,9,12,15,18; 0 -> 3,6,9,12,15,18.
- R8: Gate patterns for the negative levels, as the switches that are on: -1 -> 2,9,12,15,18; -2 -> 2,5,9,12,15,18; -3 -> 2,5,8,12,15,18; -4 -> 2,5,8,11,15,18; -5 -> 2,5,8,11,14,18; -6 -> 2,5,8,11,14,17.
- R9: gate_o is registered on the same edge as level_o, so in every cycle gate_o is the pattern of the level currently shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, the block is held in the cleared, zero-level state |
| mod_index | input | MI_W | Modulation index; 2^(MI_W-1) is full scale, and larger values are clamped |
| phase_inc | input | PHASE_W | Phase step added to the accumulator every clock |
| level_o | output | 4 | Selected level, signed, -6..+6 |
| gate_o | output | 18 | Switch commands; bit i drives switch i+1, and 1 means on |

## Verification
The bench keeps the default band width (B = 64), table depth and 32-bit accumulator. It sets PRESCALE to 3, so that strobe alignment is observable, and uses a phase increment of 2^20, so that a full sine cycle lasts exactly 4096 clocks. At these settings a single run covers both half cycles, every level, the exact peaks at index 0, half scale and clamped indices, and bounded peaks for random indices. Because the peaks are integers (three times the index), the expected extreme levels can be computed directly.

// File: rtl/lspwm_pkg.sv
`timescale 1ns/1ps
package lspwm_pkg;
   localparam int CELLS   = 6;
   localparam int LEVEL_W = 4;
   localparam int GATE_W  = 18;

   typedef logic signed [LEVEL_W-1:0] level_t;
   typedef logic [GATE_W-1:0]         gate_t;

   // zero-level pattern: switches 3,6,9,12,15,18 on
   localparam gate_t GATE_IDLE = 18'h24924;

   // rational half-wave approximation, exact at 0 and at the crest
   function automatic longint sine_pt(longint p, longint h, longint amp);
      longint u;
      u = p * (h - p);
      return (16 * u * amp) / (5 * h * h - 4 * u);
   endfunction
endpackage

// File: rtl/lspwm_nco.sv
`timescale 1ns/1ps
module lspwm_nco #(
   parameter int PHASE_W  = 32,
   parameter int LUT_BITS = 6,
   parameter int BAND_W   = 6,
   parameter int MI_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       en,
   input  logic [PHASE_W-1:0]         phase_inc,
   input  logic [MI_W-1:0]            mod_index,
   output logic signed [BAND_W+3:0]   ref_o
);
   import lspwm_pkg::*;

   localparam int Q     = 1 << LUT_BITS;
   localparam int PEAK  = CELLS << BAND_W;
   localparam int MAG_W = BAND_W + 3;
   localparam int REF_W = BAND_W + 4;
   localparam int PR_W  = MAG_W + MI_W;
   localparam logic [MI_W-1:0] FULL = MI_W'(1 << (MI_W - 1));

   logic [MAG_W-1:0] rom [Q+1];

   generate
      for (genvar i = 0; i <= Q; i++) begin : g_rom
         localparam logic [MAG_W-1:0] VAL = MAG_W'(sine_pt(i, 2 * Q, PEAK));
         assign rom[i] = VAL;
      end
   endgenerate

   logic [PHASE_W-1:0]  phase_q;
   logic                half_neg;
   logic                falling;
   logic [LUT_BITS-1:0] frac;
   logic [LUT_BITS:0]   idx;
   logic [MAG_W-1:0]    mag;
   logic [MI_W-1:0]     m_eff;
   logic [PR_W-1:0]     prod;
   logic [MAG_W-1:0]    scaled;
   logic signed [REF_W-1:0] pos;
   logic signed [REF_W-1:0] ref_d;

   always_ff @(posedge clk) begin
      if (rst || !en) phase_q <= '0;
      else            phase_q <= phase_q + phase_inc;
   end

   always_comb begin
      half_neg = phase_q[PHASE_W-1];
      falling  = phase_q[PHASE_W-2];
      frac     = phase_q[PHASE_W-3 -: LUT_BITS];
      idx      = falling ? ((LUT_BITS+1)'(Q) - {1'b0, frac}) : {1'b0, frac};
      mag      = rom[idx];
      m_eff    = (mod_index > FULL) ? FULL : mod_index;
      prod     = PR_W'(mag) * PR_W'(m_eff);
      scaled   = MAG_W'(prod >> (MI_W - 1));
      pos      = $signed({1'b0, scaled});
      ref_d    = half_neg ? -pos : pos;
   end

   always_ff @(posedge clk) begin
      if (rst || !en) ref_o <= '0;
      else            ref_o <= ref_d;
   end

   p_ref_bound_r4: assert property (@(posedge clk) disable iff (rst)
      (ref_o <= PEAK) && (ref_o >= -PEAK));

   p_ref_zero_index_r4: assert property (@(posedge clk) disable iff (rst)
      (mod_index == '0) |=> (ref_o == '0));
endmodule

// File: rtl/lspwm_carrier.sv
`timescale 1ns/1ps
module lspwm_carrier #(
   parameter int BAND_W   = 6,
   parameter int PRESCALE = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   output logic              stb_o,
   output logic [BAND_W-1:0] car_o
);
   localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [BAND_W-1:0] TOP = '1;

   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign stb_o = en;
      end else begin : g_div
         logic [PS_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || !en)                        cnt_q <= '0;
            else if (cnt_q == PS_W'(PRESCALE - 1)) cnt_q <= '0;
            else                                   cnt_q <= cnt_q + 1'b1;
         end
         assign stb_o = en && (cnt_q == PS_W'(PRESCALE - 1));
      end
   endgenerate

   logic up_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         car_o <= '0;
         up_q  <= 1'b1;
      end else if (stb_o) begin
         if (up_q) begin
            if (car_o == TOP) begin
               up_q  <= 1'b0;
               car_o <= car_o - 1'b1;
            end else begin
               car_o <= car_o + 1'b1;
            end
         end else if (car_o == '0) begin
            up_q  <= 1'b1;
            car_o <= car_o + 1'b1;
         end else begin
            car_o <= car_o - 1'b1;
         end
      end
   end

   p_car_on_sample_r6: assert property (@(posedge clk) disable iff (rst)
      (car_o != $past(car_o)) |-> ($past(stb_o) || !$past(en)));

   p_car_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(stb_o) && en) |->
         ((car_o == $past(car_o) + 1'b1) || (car_o == $past(car_o) - 1'b1)));
endmodule

// File: rtl/lspwm_classify.sv
`timescale 1ns/1ps
module lspwm_classify #(
   parameter int BAND_W = 6
) (
   input  logic signed [BAND_W+3:0] ref_i,
   input  logic [BAND_W-1:0]        car_i,
   output lspwm_pkg::level_t        lvl_o
);
   import lspwm_pkg::*;

   localparam int REF_W = BAND_W + 4;
   localparam int BAND  = 1 << BAND_W;

   logic signed [REF_W-1:0] car_s;
   logic [CELLS-1:0] above;
   logic [CELLS-1:0] below;

   assign car_s = $signed(REF_W'(car_i));

   generate
      for (genvar k = 0; k < CELLS; k++) begin : g_cmp
         localparam logic signed [REF_W-1:0] OFS = REF_W'(k * BAND);
         logic signed [REF_W-1:0] carrier;
         assign carrier  = OFS + car_s;
         assign above[k] = ref_i > carrier;
         assign below[k] = ref_i < -carrier;
      end
   endgenerate

   always_comb begin
      lvl_o = level_t'($countones(above)) - level_t'($countones(below));
   end
endmodule

// File: rtl/lspwm_gatemap.sv
`timescale 1ns/1ps
module lspwm_gatemap (
   input  lspwm_pkg::level_t lvl_i,
   output lspwm_pkg::gate_t  gate_o
);
   logic [8:0] lo;
   logic [8:0] hi;
   int         v;

   always_comb begin
      v = int'(lvl_i);
      // switches 1..9
      if (v >= 3)        lo = 9'h049;
      else if (v == 2)   lo = 9'h129;
      else if (v == 1)   lo = 9'h121;
      else if (v == 0)   lo = 9'h124;
      else if (v == -1)  lo = 9'h102;
      else if (v == -2)  lo = 9'h112;
      else               lo = 9'h092;
      // switches 10..18
      if (v >= 6)        hi = 9'h049;
      else if (v == 5)   hi = 9'h109;
      else if (v == 4)   hi = 9'h121;
      else if (v >= -3)  hi = 9'h124;
      else if (v == -4)  hi = 9'h122;
      else if (v == -5)  hi = 9'h112;
      else               hi = 9'h092;
      gate_o = {hi, lo};
   end
endmodule

// File: rtl/lspwm_modulator.sv
`timescale 1ns/1ps
module lspwm_modulator #(
   parameter int PHASE_W  = 32,
   parameter int LUT_BITS = 6,
   parameter int BAND_W   = 6,
   parameter int MI_W     = 8,
   parameter int PRESCALE = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [MI_W-1:0]    mod_index,
   input  logic [PHASE_W-1:0] phase_inc,
   output logic signed [3:0]  level_o,
   output logic [17:0]        gate_o
);
   import lspwm_pkg::*;

   localparam int REF_W = BAND_W + 4;

   generate
      if (BAND_W < 2)                  begin : g_chk_band  $error("BAND_W below 2"); end
      if (LUT_BITS < 2)                begin : g_chk_lut   $error("LUT_BITS below 2"); end
      if (MI_W < 2)                    begin : g_chk_mi    $error("MI_W below 2"); end
      if (PRESCALE < 1)                begin : g_chk_ps    $error("PRESCALE below 1"); end
      if (PHASE_W < LUT_BITS + 2)      begin : g_chk_phase $error("PHASE_W too small"); end
   endgenerate

   logic signed [REF_W-1:0] ref_w;
   logic [BAND_W-1:0]       car_w;
   logic                    stb_w;
   level_t                  lvl_next;
   gate_t                   gate_next;

   lspwm_nco #(
      .PHASE_W (PHASE_W),
      .LUT_BITS(LUT_BITS),
      .BAND_W  (BAND_W),
      .MI_W    (MI_W)
   ) u_nco (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .phase_inc(phase_inc),
      .mod_index(mod_index),
      .ref_o    (ref_w)
   );

   lspwm_carrier #(
      .BAND_W  (BAND_W),
      .PRESCALE(PRESCALE)
   ) u_car (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .stb_o(stb_w),
      .car_o(car_w)
   );

   lspwm_classify #(
      .BAND_W(BAND_W)
   ) u_cls (
      .ref_i(ref_w),
      .car_i(car_w),
      .lvl_o(lvl_next)
   );

   lspwm_gatemap u_map (
      .lvl_i (lvl_next),
      .gate_o(gate_next)
   );

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         level_o <= '0;
         gate_o  <= GATE_IDLE;
      end else if (stb_w) begin
         level_o <= lvl_next;
         gate_o  <= gate_next;
      end
   end

   p_idle_when_off_r1: assert property (@(posedge clk) disable iff (rst)
      !en |=> ((level_o == '0) && (gate_o == GATE_IDLE)));

   p_level_range_r2: assert property (@(posedge clk) disable iff (rst)
      (level_o >= -4'sd6) && (level_o <= 4'sd6));

   p_change_on_sample_r6: assert property (@(posedge clk) disable iff (rst)
      (level_o != $past(level_o)) |-> ($past(stb_w) || !$past(en)));

   p_top_pattern_r7: assert property (@(posedge clk) disable iff (rst)
      (level_o == 4'sd6) |-> (gate_o == 18'h09249));

   p_zero_pattern_r9: assert property (@(posedge clk) disable iff (rst)
      (level_o == '0) |-> (gate_o == GATE_IDLE));
endmodule

// File: tb/tb_lspwm_modulator.sv
`timescale 1ns/1ps
module tb_lspwm_modulator;
   localparam int PHASE_W = 32;
   localparam int MI_W    = 8;
   localparam int PS      = 3;
   localparam int PERIOD  = 4096;
   localparam int HALF    = PERIOD / 2;
   localparam int GUARD   = 16;
   localparam logic [PHASE_W-1:0] INC = 32'h0010_0000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              en  = 1'b1;
   logic [MI_W-1:0]   mod_index = 8'd128;
   logic [PHASE_W-1:0] phase_inc = INC;
   logic signed [3:0] level_o;
   logic [17:0]       gate_o;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lspwm_modulator #(
      .PHASE_W (PHASE_W),
      .MI_W    (MI_W),
      .PRESCALE(PS)
   ) dut (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .mod_index(mod_index),
      .phase_inc(phase_inc),
      .level_o  (level_o),
      .gate_o   (gate_o)
   );

   function automatic logic [17:0] b(int n);
      return 18'(1) << (n - 1);
   endfunction

   function automatic logic [17:0] exp_gate(int lv);
      case (lv)
          6: return b(1)|b(4)|b(7)|b(10)|b(13)|b(16);
          5: return b(1)|b(4)|b(7)|b(10)|b(13)|b(18);
          4: return b(1)|b(4)|b(7)|b(10)|b(15)|b(18);
          3: return b(1)|b(4)|b(7)|b(12)|b(15)|b(18);
          2: return b(1)|b(4)|b(6)|b(9)|b(12)|b(15)|b(18);
          1: return b(1)|b(6)|b(9)|b(12)|b(15)|b(18);
          0: return b(3)|b(6)|b(9)|b(12)|b(15)|b(18);
         -1: return b(2)|b(9)|b(12)|b(15)|b(18);
         -2: return b(2)|b(5)|b(9)|b(12)|b(15)|b(18);
         -3: return b(2)|b(5)|b(8)|b(12)|b(15)|b(18);
         -4: return b(2)|b(5)|b(8)|b(11)|b(15)|b(18);
         -5: return b(2)|b(5)|b(8)|b(11)|b(14)|b(18);
         default: return b(2)|b(5)|b(8)|b(11)|b(14)|b(17);
      endcase
   endfunction

   function automatic int peak_level(int m);
      int mm;
      int k;
      mm = (m > 128) ? 128 : m;
      k  = (3 * mm + 63) / 64;
      return (k > 6) ? 6 : k;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   // one full sine cycle from a fresh enable; exact selects exact peak check
   task automatic run_wave(input int m, input bit exact);
      int first_chg;
      int prev;
      int mx;
      int mn;
      int lv;
      int k;
      logic [12:0] seen;
      @(negedge clk);
      en = 1'b0;
      mod_index = MI_W'(m);
      repeat (2) @(negedge clk);
      chk(level_o == 0 && gate_o == exp_gate(0), "R1 idle", int'(gate_o), int'(exp_gate(0)));
      en = 1'b1;
      first_chg = -1; prev = 0; mx = -99; mn = 99; seen = '0;
      for (int t = 0; t < PERIOD; t++) begin
         @(negedge clk);
         lv = int'(level_o);
         chk(lv >= -6 && lv <= 6, "R2 range", lv, 0);
         if (lv >= 0) chk(gate_o == exp_gate(lv), "R7 gate", int'(gate_o), int'(exp_gate(lv)));
         else         chk(gate_o == exp_gate(lv), "R8 gate", int'(gate_o), int'(exp_gate(lv)));
         if (lv != prev) begin
            chk(gate_o == exp_gate(lv), "R9 gate follows level", int'(gate_o), int'(exp_gate(lv)));
            if (first_chg < 0) first_chg = t;
            else chk(((t - first_chg) % PS) == 0, "R6 strobe alignment", t - first_chg, PS);
         end
         if (t >= GUARD && t < HALF - GUARD)
            chk(lv >= 0, "R5 first half sign", lv, 0);
         if (t >= HALF + GUARD && t < PERIOD - GUARD)
            chk(lv <= 0, "R5 second half sign", lv, 0);
         if (lv > mx) mx = lv;
         if (lv < mn) mn = lv;
         seen[lv + 6] = 1'b1;
         prev = lv;
      end
      k = peak_level(m);
      if (exact) begin
         chk(mx == k, "R4 positive peak", mx, k);
         chk(mn == -k, "R4 negative peak", mn, -k);
      end else begin
         chk(mx <= k && mx >= k - 1, "R4 positive peak bound", mx, k);
         chk(mn >= -k && mn <= -k + 1, "R4 negative peak bound", mn, -k);
      end
      if (k == 6)
         chk(seen == 13'h1fff, "R3 all levels visited", int'(seen), 32'h1fff);
   endtask

   initial begin
      #(150000 * 20);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd2718));
      // reset state with enable high
      repeat (3) @(negedge clk);
      chk(level_o == 0, "R1 reset level", int'(level_o), 0);
      chk(gate_o == 18'h24924, "R1 reset gate", int'(gate_o), 32'h24924);
      rst = 1'b0;

      // directed: full scale, zero, half scale, clamped indices
      run_wave(128, 1'b1);
      run_wave(0,   1'b1);
      run_wave(64,  1'b1);
      run_wave(255, 1'b1);
      run_wave(200, 1'b1);

      // disable mid-cycle near the crest: idle on the next edge (R1)
      @(negedge clk);
      en = 1'b0;
      mod_index = 8'd128;
      repeat (2) @(negedge clk);
      en = 1'b1;
      repeat (1024) @(negedge clk);
      chk(level_o > 0, "R3 crest level positive", int'(level_o), 6);
      en = 1'b0;
      @(negedge clk);
      chk(level_o == 0 && gate_o == 18'h24924, "R1 disable clears", int'(gate_o), 32'h24924);

      // random indices below and above full scale
      for (int i = 0; i < 5; i++) begin
         int m;
         m = 1 + int'($urandom_range(126));
         run_wave(m, 1'b0);
      end
      for (int i = 0; i < 2; i++) begin
         int m;
         m = 129 + int'($urandom_range(126));
         run_wave(m, 1'b1);
      end

      summary();
   end
endmodule